// File: doc/BRIEF.md
# Packet-Committing Slave Write FIFO

This block is the write-facing side of a multi-endpoint packet buffer. An external master holds an address naming one of several lanes. On each rising edge it may drive a chip select, a write strobe, a data word and a packet-end strobe. Every accepted word joins the open packet of the addressed lane. A packet closes in one of two ways. In auto mode it closes by itself once its word count reaches a programmed length. Otherwise the master closes it with the packet-end strobe, which also works in auto mode. The strobe may arrive on the same edge as the last word, and that word then belongs to the packet. It may also arrive on a later idle cycle, and it then closes whatever is buffered, which can be nothing at all.

Each lane keeps its words in a circular store and its closed packet lengths in a small descriptor queue. Each lane drives full, empty and sticky overflow flags. Closed packets leave through a single valid/ready stream. Every beat carries the word, the packet length, the source lane and a last marker. The beat is offered while valid is high and moves only on an edge where ready is also high. While ready is low, every field holds still, so a slow consumer stalls the stream without losing anything. Lane storage depth must be a power of two or any value of at least two. The descriptor queue depth must be at least two.

Top module: `pkt_wr_fifo`

## Requirements
- R1: A lane is written only on a rising edge where `wr_cs` and `wr_en` are both 1 and `wr_addr` equals the lane index. A packet-end strobe counts only when `wr_cs` is 1, and it acts on the lane that `wr_addr` names. When the strobe is low, or when `wr_cs` is low, nothing changes in any lane.
- R2: With select and strobe held high, one word is captured on every edge, in order. `fifo_empty[i]` and `fifo_full[i]` show the new occupancy from the cycle after the edge that changed it. A lane is empty when it holds no words and no closed packets.
- R3: With `auto_mode` at 1, a write that brings the open packet's word count to `auto_len` closes a packet of that length on the same edge. A value of 0 in `auto_len` never closes a packet.
- R4: A packet-end strobe on the same edge as an accepted write closes a packet that includes that word. This also holds when that word is the one that reaches `auto_len`: a single packet is produced.
- R5: A packet-end strobe with no accepted write closes the words already buffered. If none are buffered, it closes a zero-length packet. That packet is sent as one beat with `m_len` = 0 and `m_last` = 1, and its data is meaningless.
- R6: After an auto-closed packet, a write plus strobe on a following cycle produces a separate one-word packet.
- R7: A lane is full when its store holds DEPTH words or its descriptor queue holds DESC_DEPTH packets. Writes to a full lane are dropped and set `fifo_overflow[i]`. A strobe while the descriptor queue is full is ignored and also sets that bit. Overflow bits stay set until reset.
- R8: The output stream is valid/ready. While `m_valid` is 1 and `m_ready` is 0, the control fields `m_len`, `m_last` and `m_fifo` hold steady. `m_data` also holds steady whenever `m_len` is not 0. Each beat carries the packet length, and `m_last` is 1 only on the final beat.
- R9: Once a packet starts, its beats are not interleaved with another lane's. When the stream is idle, the lowest-numbered lane holding a closed packet is served next.
- R10: After reset, all lanes are empty, none is full, no overflow bit is set and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr | input | ADDR_W | Lane selected by the master |
| wr_cs | input | 1 | Chip select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data word |
| pkt_end | input | 1 | Packet-end strobe |
| auto_mode | input | 1 | 1 = close packets automatically at `auto_len` |
| auto_len | input | LEN_W | Automatic packet length |
| fifo_full | output | NUM_FIFOS | Per-lane full flag |
| fifo_empty | output | NUM_FIFOS | Per-lane empty flag |
| fifo_overflow | output | NUM_FIFOS | Per-lane sticky dropped-write flag |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | DATA_W | Output word |
| m_len | output | LEN_W | Length of the packet this beat belongs to |
| m_last | output | 1 | Final beat of the packet |
| m_fifo | output | ADDR_W | Lane the packet came from |

## Verification
The hardest situations to reach are the overlaps on the lane control path. One is a strobe landing on the very edge where an auto-closing write occurs. Another is a strobe one cycle after that edge with nothing written. A third is a lane whose descriptor queue is full while its word store is empty. The bench reaches these by driving exact cycle sequences with the stream stalled, so that packets stack up. It then drains them and compares every beat's length, last marker and data against a model built from the requirements. Arbitration order is forced by keeping `m_ready` low while a high-numbered lane locks the stream, then closing packets on lower lanes before releasing it.

// File: rtl/pwf_pkg.sv
`timescale 1ns/1ps
package pwf_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_SEND = 1'b1
  } arb_state_e;
endpackage

// File: rtl/pwf_lane.sv
`timescale 1ns/1ps
module pwf_lane #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int DESC_DEPTH = 4,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              pe_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              auto_mode,
  input  logic [LEN_W-1:0]  auto_len,
  input  logic              pop_word,
  input  logic              pop_desc,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              desc_avail,
  output logic [LEN_W-1:0]  head_len,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DP_W  = $clog2(DESC_DEPTH);
  localparam int DC_W  = $clog2(DESC_DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [LEN_W-1:0]  desc_len [DESC_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LEN_W-1:0]  word_cnt, open_cnt;
  logic [DP_W-1:0]   dwr_ptr, drd_ptr;
  logic [DC_W-1:0]   desc_cnt;

  logic store_full, desc_full, take_word, strobe_ok, auto_hit, close_pkt;
  logic [LEN_W-1:0] close_len;

  assign store_full = (word_cnt == LEN_W'(DEPTH));
  assign desc_full  = (desc_cnt == DC_W'(DESC_DEPTH));
  assign full       = store_full | desc_full;
  assign empty      = (word_cnt == '0) && (desc_cnt == '0);
  assign take_word  = wr_req & ~full;
  assign strobe_ok  = pe_req & ~desc_full;
  assign auto_hit   = auto_mode & take_word & ((open_cnt + LEN_W'(1)) == auto_len);
  assign close_pkt  = strobe_ok | auto_hit;
  assign close_len  = open_cnt + LEN_W'(take_word);

  assign desc_avail = (desc_cnt != '0);
  assign head_len   = desc_len[drd_ptr];
  assign rd_data    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (take_word) store[wr_ptr] <= wr_data;
    if (close_pkt) desc_len[dwr_ptr] <= close_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      word_cnt <= '0;
      open_cnt <= '0;
      dwr_ptr  <= '0;
      drd_ptr  <= '0;
      desc_cnt <= '0;
      overflow <= 1'b0;
    end else begin
      if (take_word) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop_word)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      word_cnt <= word_cnt + LEN_W'(take_word) - LEN_W'(pop_word);
      open_cnt <= close_pkt ? '0 : close_len;
      if (close_pkt) dwr_ptr <= (dwr_ptr == DP_W'(DESC_DEPTH - 1)) ? '0 : dwr_ptr + DP_W'(1);
      if (pop_desc)  drd_ptr <= (drd_ptr == DP_W'(DESC_DEPTH - 1)) ? '0 : drd_ptr + DP_W'(1);
      desc_cnt <= desc_cnt + DC_W'(close_pkt) - DC_W'(pop_desc);
      if ((wr_req & full) | (pe_req & desc_full)) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pwf_out_arb.sv
`timescale 1ns/1ps
module pwf_out_arb
  import pwf_pkg::*;
#(
  parameter int NUM_FIFOS = 4,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 5,
  parameter int ADDR_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_FIFOS-1:0]             desc_avail,
  input  logic [NUM_FIFOS-1:0][LEN_W-1:0]  head_len,
  input  logic [NUM_FIFOS-1:0][DATA_W-1:0] rd_data,
  input  logic                             m_ready,
  output logic [NUM_FIFOS-1:0]             pop_word,
  output logic [NUM_FIFOS-1:0]             pop_desc,
  output logic                             m_valid,
  output logic [DATA_W-1:0]                m_data,
  output logic [LEN_W-1:0]                 m_len,
  output logic                             m_last,
  output logic [ADDR_W-1:0]                m_fifo
);
  arb_state_e       state;
  logic [ADDR_W-1:0] sel, pick_idx;
  logic [LEN_W-1:0]  beat, cur_len;
  logic              found, is_last, fire;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = NUM_FIFOS - 1; i >= 0; i--) begin
      if (desc_avail[i]) begin
        found    = 1'b1;
        pick_idx = ADDR_W'(i);
      end
    end
  end

  assign cur_len = head_len[sel];
  assign is_last = (cur_len == '0) || (beat == cur_len - LEN_W'(1));
  assign m_valid = (state == ARB_SEND);
  assign fire    = m_valid & m_ready;
  assign m_data  = rd_data[sel];
  assign m_len   = cur_len;
  assign m_last  = m_valid & is_last;
  assign m_fifo  = sel;

  always_comb begin
    pop_word = '0;
    pop_desc = '0;
    if (fire) begin
      pop_word[sel] = (cur_len != '0);
      pop_desc[sel] = is_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ARB_IDLE;
      sel   <= '0;
      beat  <= '0;
    end else begin
      case (state)
        ARB_IDLE: if (found) begin
          state <= ARB_SEND;
          sel   <= pick_idx;
          beat  <= '0;
        end
        ARB_SEND: if (fire) begin
          if (is_last) begin
            state <= ARB_IDLE;
            beat  <= '0;
          end else begin
            beat <= beat + LEN_W'(1);
          end
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_wr_fifo.sv
`timescale 1ns/1ps
module pkt_wr_fifo #(
  parameter int NUM_FIFOS  = 4,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int DESC_DEPTH = 4,
  localparam int ADDR_W    = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1,
  localparam int LEN_W     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_cs,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 pkt_end,
  input  logic                 auto_mode,
  input  logic [LEN_W-1:0]     auto_len,
  output logic [NUM_FIFOS-1:0] fifo_full,
  output logic [NUM_FIFOS-1:0] fifo_empty,
  output logic [NUM_FIFOS-1:0] fifo_overflow,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [DATA_W-1:0]    m_data,
  output logic [LEN_W-1:0]     m_len,
  output logic                 m_last,
  output logic [ADDR_W-1:0]    m_fifo
);
  logic [NUM_FIFOS-1:0]             desc_avail, pop_word, pop_desc;
  logic [NUM_FIFOS-1:0][LEN_W-1:0]  head_len;
  logic [NUM_FIFOS-1:0][DATA_W-1:0] rd_data;

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_lane
    logic hit;
    assign hit = wr_cs && (wr_addr == ADDR_W'(g));
    pwf_lane #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .DESC_DEPTH(DESC_DEPTH), .LEN_W(LEN_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_req(hit & wr_en), .pe_req(hit & pkt_end),
      .wr_data(wr_data), .auto_mode(auto_mode), .auto_len(auto_len),
      .pop_word(pop_word[g]), .pop_desc(pop_desc[g]),
      .full(fifo_full[g]), .empty(fifo_empty[g]), .overflow(fifo_overflow[g]),
      .desc_avail(desc_avail[g]), .head_len(head_len[g]), .rd_data(rd_data[g])
    );
  end

  pwf_out_arb #(
    .NUM_FIFOS(NUM_FIFOS), .DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .desc_avail(desc_avail), .head_len(head_len), .rd_data(rd_data),
    .m_ready(m_ready), .pop_word(pop_word), .pop_desc(pop_desc),
    .m_valid(m_valid), .m_data(m_data), .m_len(m_len),
    .m_last(m_last), .m_fifo(m_fifo)
  );
endmodule

// File: rtl/pwf_chk.sv
`timescale 1ns/1ps
module pwf_chk #(
  parameter int NUM_FIFOS = 4,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 5,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_cs,
  input logic                 wr_en,
  input logic                 pkt_end,
  input logic [NUM_FIFOS-1:0] fifo_full,
  input logic [NUM_FIFOS-1:0] fifo_overflow,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic [DATA_W-1:0]    m_data,
  input logic [LEN_W-1:0]     m_len,
  input logic                 m_last,
  input logic [ADDR_W-1:0]    m_fifo
);
  // R8
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_len) && $stable(m_last) && $stable(m_fifo));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && (m_len != '0) |=> $stable(m_data));

  // R5
  zero_len_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && (m_len == '0) |-> m_last);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid || !m_valid |=> (fifo_overflow & $past(fifo_overflow)) == $past(fifo_overflow));

  // R1
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cs && (wr_en || pkt_end)) |=> (fifo_full & ~$past(fifo_full)) == '0);

  // R9
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_last |=> m_valid && $stable(m_fifo));
endmodule

bind pkt_wr_fifo pwf_chk #(
  .NUM_FIFOS(NUM_FIFOS), .DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_pwf_chk (
  .clk(clk), .rst_n(rst_n), .wr_cs(wr_cs), .wr_en(wr_en), .pkt_end(pkt_end),
  .fifo_full(fifo_full), .fifo_overflow(fifo_overflow),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_len(m_len),
  .m_last(m_last), .m_fifo(m_fifo)
);

// File: tb/test_pkt_wr_fifo.sv
`timescale 1ns/1ps
module test_pkt_wr_fifo;
  localparam int NF  = 4;
  localparam int DW  = 8;
  localparam int DEP = 8;
  localparam int DD  = 4;
  localparam int AW  = 2;
  localparam int LW  = $clog2(DEP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_cs = 0, wr_en = 0, pkt_end = 0, auto_mode = 0, m_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] auto_len = '0;
  logic [NF-1:0] fifo_full, fifo_empty, fifo_overflow;
  logic m_valid, m_last;
  logic [DW-1:0] m_data;
  logic [LW-1:0] m_len;
  logic [AW-1:0] m_fifo;

  always #10 clk = ~clk;

  pkt_wr_fifo #(.NUM_FIFOS(NF), .DATA_W(DW), .DEPTH(DEP), .DESC_DEPTH(DD)) i_pkt_wr_fifo (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_cs(wr_cs), .wr_en(wr_en),
    .wr_data(wr_data), .pkt_end(pkt_end), .auto_mode(auto_mode), .auto_len(auto_len),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_len(m_len),
    .m_last(m_last), .m_fifo(m_fifo));

  int checks = 0, fails = 0;
  int mcnt [NF], mdc [NF], mopen [NF];
  logic [NF-1:0] movf;
  int qlen [NF][$];
  int qwrd [NF][$];
  int ord [$];
  int cur_beat;

  // cs, en, pe, addr[1:0], data[7:0], expected empty mask[3:0]
  localparam logic [16:0] TV [9] = '{
    {3'b110, 2'd0, 8'h11, 4'b1110},
    {3'b010, 2'd1, 8'h22, 4'b1110},
    {3'b100, 2'd1, 8'h33, 4'b1110},
    {3'b110, 2'd1, 8'h44, 4'b1100},
    {3'b110, 2'd1, 8'h45, 4'b1100},
    {3'b111, 2'd1, 8'h46, 4'b1100},
    {3'b101, 2'd0, 8'h00, 4'b1100},
    {3'b101, 2'd2, 8'h00, 4'b1000},
    {3'b001, 2'd3, 8'h00, 4'b1000}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    logic [NF-1:0] ee, ef;
    for (int i = 0; i < NF; i++) begin
      ee[i] = (mcnt[i] == 0) && (mdc[i] == 0);
      ef[i] = (mcnt[i] == DEP) || (mdc[i] == DD);
    end
    check(fifo_empty == ee, {tag, " R2 empty"}, fifo_empty, ee);
    check(fifo_full == ef, {tag, " R7 full"}, fifo_full, ef);
    check(fifo_overflow == movf, {tag, " R7 overflow"}, fifo_overflow, movf);
  endtask

  task automatic cyc(input bit cs, input bit en, input bit pe, input int a, input int d);
    bit mf, w, ah, com;
    wr_cs = cs; wr_en = en; pkt_end = pe; wr_addr = AW'(a); wr_data = DW'(d);
    mf = (mcnt[a] == DEP) || (mdc[a] == DD);
    w  = cs && en && !mf;
    if (cs && en && mf) movf[a] = 1'b1;
    if (cs && pe && mdc[a] == DD) movf[a] = 1'b1;
    ah  = auto_mode && w && (mopen[a] + 1 == int'(auto_len));
    com = (cs && pe && mdc[a] != DD) || ah;
    if (w) begin qwrd[a].push_back(d); mcnt[a]++; end
    if (com) begin
      qlen[a].push_back(mopen[a] + int'(w)); mdc[a]++; mopen[a] = 0;
    end else mopen[a] += int'(w);
    @(posedge clk); @(negedge clk);
    wr_cs = 0; wr_en = 0; pkt_end = 0;
  endtask

  task automatic drain(input string tag);
    int f, el, guard;
    bit lst, all_empty;
    ord.delete();
    cur_beat = 0;
    m_ready = 1'b1;
    guard = 0;
    forever begin
      all_empty = 1'b1;
      for (int i = 0; i < NF; i++) if (qlen[i].size() != 0) all_empty = 1'b0;
      if (all_empty || guard > 400) break;
      guard++;
      if (m_valid) begin
        f = int'(m_fifo);
        if (qlen[f].size() == 0) begin
          check(1'b0, {tag, " R8 unexpected packet lane"}, f, -1);
          break;
        end
        el  = qlen[f][0];
        lst = (el == 0) || (cur_beat == el - 1);
        if (cur_beat == 0) ord.push_back(f);
        check(int'(m_len) == el, {tag, " R8 length"}, m_len, el);
        check(m_last == lst, {tag, " R8 last"}, m_last, lst);
        if (el > 0) check(int'(m_data) == qwrd[f][0], {tag, " data"}, m_data, qwrd[f][0]);
        @(posedge clk);
        if (el > 0) begin void'(qwrd[f].pop_front()); mcnt[f]--; end
        if (lst) begin void'(qlen[f].pop_front()); mdc[f]--; cur_beat = 0; end
        else cur_beat++;
        @(negedge clk);
      end else begin
        @(posedge clk); @(negedge clk);
      end
    end
    check(guard <= 400, {tag, " R8 drain finished"}, guard, 400);
    m_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(m_valid == 1'b0, {tag, " R8 no extra packet"}, m_valid, 0);
    check_flags(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NF; i++) begin mcnt[i] = 0; mdc[i] = 0; mopen[i] = 0; end
    movf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(fifo_empty == '1, "R10 empty", fifo_empty, 4'hF);
    check(fifo_full == '0, "R10 full", fifo_full, 0);
    check(fifo_overflow == '0, "R10 overflow", fifo_overflow, 0);
    check(m_valid == 1'b0, "R10 valid", m_valid, 0);

    // Vector table: R1 ignored writes and strobes, R4 and R5 manual closes
    for (int r = 0; r < 9; r++) begin
      cyc(TV[r][16], TV[r][15], TV[r][14], int'(TV[r][13:12]), int'(TV[r][11:4]));
      check(fifo_empty == TV[r][3:0], $sformatf("R1 R2 table row %0d", r), fifo_empty, TV[r][3:0]);
      check_flags($sformatf("table row %0d", r));
    end
    // R8 stalled stream holds lane 1 packet head
    for (int k = 0; k < 3; k++) begin
      check(m_valid && m_fifo == 2'd1 && m_len == LW'(3) && m_data == 8'h44 && !m_last,
            "R8 stall hold", {m_fifo, m_len, m_data}, {2'd1, 4'd3, 8'h44});
      cyc(0, 0, 0, 0, 0);
    end
    drain("R4 R5 table");
    check(ord.size() == 3 && ord[0] == 1 && ord[1] == 0 && ord[2] == 2, "R9 table order",
          (ord.size() == 3) ? ord[1] : -1, 0);

    // R3 auto close, R6 later one-word close, R5 zero after auto, R4 strobe on auto edge
    auto_mode = 1'b1; auto_len = LW'(3);
    cyc(1, 1, 0, 2, 'hA0); cyc(1, 1, 0, 2, 'hA1); cyc(1, 1, 0, 2, 'hA2);
    check(qlen[2].size() == 1, "R3 model closed", qlen[2].size(), 1);
    cyc(1, 1, 1, 2, 'hA3);
    cyc(1, 0, 1, 2, 0);
    cyc(1, 1, 0, 2, 'hC0); cyc(1, 1, 0, 2, 'hC1); cyc(1, 1, 1, 2, 'hC2);
    check_flags("R3 auto");
    drain("R3 R4 R6 auto");
    auto_mode = 1'b0; auto_len = '0;

    // R7 word store full, drop and overflow
    for (int i = 0; i < DEP; i++) cyc(1, 1, 0, 3, 'h30 + i);
    check(fifo_full[3] == 1'b1, "R7 store full", fifo_full[3], 1);
    cyc(1, 1, 0, 3, 'hEE);
    check(fifo_overflow[3] == 1'b1, "R7 overflow set", fifo_overflow[3], 1);
    cyc(1, 0, 1, 3, 0);
    drain("R7 store");

    // R7 descriptor queue full with an empty store
    for (int i = 0; i < DD; i++) cyc(1, 0, 1, 1, 0);
    check(fifo_full[1] == 1'b1 && fifo_empty[1] == 1'b0, "R7 desc full", fifo_full[1], 1);
    cyc(1, 1, 0, 1, 'h77);
    cyc(1, 0, 1, 1, 0);
    check(fifo_overflow[1] == 1'b1, "R7 desc overflow", fifo_overflow[1], 1);
    drain("R7 desc");
    check(fifo_empty[1] == 1'b1, "R7 dropped word absent", fifo_empty[1], 1);

    // R9 lock on lane 3, then lowest lane first
    cyc(1, 1, 1, 3, 'h51);
    cyc(1, 1, 1, 1, 'h52);
    cyc(1, 1, 1, 0, 'h53);
    drain("R9 priority");
    check(ord.size() == 3 && ord[0] == 3 && ord[1] == 0 && ord[2] == 1, "R9 order",
          (ord.size() == 3) ? ord[1] : -1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule